// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block keeps calendar time in seven packed-BCD registers (seconds, minutes, hours, day of month, month, year within the century, and day of week). It advances on a one-pulse-per-second tick input. A host reaches every register through a plain byte-wide port made of an address, a write enable, write data and combinational read data.

To set the time, the host first sets a stop bit in the control register. While the clock is frozen, the host loads the time registers and then clears the stop bit to resume counting. A sticky power-up flag in the status register starts set and marks the time as untrustworthy until software clears it by writing a one.

The calendar has one deliberate oddity: November is counted as a 31-day month. Software that reads the registers must correct for this itself. February gets 29 days in years whose two-digit value is a multiple of four.

Top module: `bcd_rtc_regfile`

## Requirements
- R1: After reset the time reads 00 s, 00 min, 00 h, day 01, month 01, year 00, weekday 0. The stop bit reads 0 and the power-up flag reads 1 (status byte 0x80).
- R2: Register map:
  - Offsets 0x0 to 0x6 hold seconds, minutes, hours, day, month, year and weekday, in that order.
  - The control byte sits at 0x8, with the stop bit in bit 0.
  - The status byte sits at 0x9, with the power-up flag in bit 7.
  - Any other offset reads 0x00.
  - Bits a field does not implement read 0. Field widths are seconds 7, minutes 7, hours 6, day 6, month 5, year 8 and weekday 3 bits.
  - Read data is combinational from the address.
- R3: While the stop bit is 1, ticks are ignored. A write to a time register is visible from the clock edge that samples it.
- R4: While the stop bit is 0, writes to time registers have no effect.
- R5: Each tick taken while running increments seconds in BCD. Seconds and minutes wrap from 59 to 00 and carry upward. Hours wrap from 23 to 00 and carry into the day.
- R6: April, June and September end after day 30. November ends after day 31, so 30 Nov is followed by 31 Nov and then 1 Dec. Every other month except February ends after day 31.
- R7: February ends after day 29 when the year value is divisible by 4, and after day 28 otherwise.
- R8: Day overflow wraps the day to 01 and increments the month. Month 12 wraps to 01 and increments the year. Year 99 wraps to 00.
- R9: The weekday counts 0 to 6, wraps to 0, and advances exactly when the day advances.
- R10: Writing a status byte with bit 7 set clears the power-up flag. A byte with bit 7 clear leaves the flag unchanged. Once cleared, only reset sets the flag again.
- R11: A field loaded at or above its upper limit returns to its start value on its next increment and passes a carry on. For example, seconds 0x75 becomes 00 and minutes increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickIn | input | 1 | One-cycle pulse once per second |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register offset |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte for regAddr |

## Verification
The transitions that matter most happen only at the last second of a month, so they are out of reach by ticking from reset. These are 30 to 31 November, 31 November to 1 December, the February end in leap and common years, and the year-99 rollover. The stimulus reaches each one by stopping the clock, loading that date at 23:59:59 through the port, restarting, and giving a single tick. Every month of one common and one leap year is swept this way, and so is the February end for all hundred year values. A 3700-tick run covers the second, minute and hour digit carries.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DAY  = 3;
  localparam int IDX_MON  = 4;
  localparam int IDX_YEAR = 5;
  localparam int IDX_WDAY = 6;

  // Strobes from the control side to the time datapath.
  typedef struct packed {
    logic                  advance;
    logic [NUM_FIELDS-1:0] wrTime;
    logic [7:0]            wrByte;
  } rtcStrobe_t;

  // Packed-BCD increment: low digit 9 (or beyond) rolls into the tens digit.
  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] fieldMask(input int idx);
    case (idx)
      IDX_SEC, IDX_MIN:   return 8'h7F;
      IDX_HOUR, IDX_DAY:  return 8'h3F;
      IDX_MON:            return 8'h1F;
      IDX_YEAR:           return 8'hFF;
      default:            return 8'h07;
    endcase
  endfunction

  function automatic logic [7:0] fieldStart(input int idx);
    if (idx == IDX_DAY || idx == IDX_MON) return 8'h01;
    else                                  return 8'h00;
  endfunction

  // Divisible by four, decided on the BCD digits directly.
  function automatic logic isLeap(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  // Last day of a month; November is kept at 31 on purpose.
  function automatic logic [7:0] monthLastDay(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:               return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09: return 8'h30;
      default:             return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        wrData,
  output rtcStrobe_t        strb,
  output logic              stopBit,
  output logic              powerFlag
);

  logic stopQ;
  logic flagQ;
  logic ctrlHit;
  logic statHit;

  assign ctrlHit = wrEn && (regAddr == CTRL_ADDR);
  assign statHit = wrEn && (regAddr == STAT_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopQ <= 1'b0;
      flagQ <= 1'b1;
    end else begin
      if (ctrlHit) stopQ <= wrData[0];
      if (statHit && wrData[7]) flagQ <= 1'b0;
    end
  end

  // Time writes only land while frozen; ticks only count while running.
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_wrdec
    assign strb.wrTime[i] = wrEn && stopQ && (regAddr == ADDR_W'(i));
  end
  assign strb.advance = tickIn && !stopQ;
  assign strb.wrByte  = wrData;

  assign stopBit   = stopQ;
  assign powerFlag = flagQ;

  // R10: once cleared, the power-up flag stays cleared until reset
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !flagQ |=> !flagQ);

  // R3: a tick while stopped is never passed on as an advance
  a_r3_no_advance_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (stopQ && tickIn) |-> !strb.advance);

endmodule

// File: rtl/rtc_time_path.sv
module rtc_time_path
  import rtc_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  rtcStrobe_t                      strb,
  output logic [NUM_FIELDS-1:0][7:0]      timeBytes
);

  logic [NUM_FIELDS-1:0][7:0] timeQ;
  logic [NUM_FIELDS-1:0][7:0] limitVal;
  logic [NUM_FIELDS-1:0]      atLimit;
  logic [NUM_FIELDS-1:0]      carryIn;
  logic                       leapYear;

  assign leapYear = isLeap(timeQ[IDX_YEAR]);

  always_comb begin
    limitVal[IDX_SEC]  = 8'h59;
    limitVal[IDX_MIN]  = 8'h59;
    limitVal[IDX_HOUR] = 8'h23;
    limitVal[IDX_DAY]  = monthLastDay(timeQ[IDX_MON], leapYear);
    limitVal[IDX_MON]  = 8'h12;
    limitVal[IDX_YEAR] = 8'h99;
    limitVal[IDX_WDAY] = 8'h06;
  end

  // Single-cycle ripple of the carry from seconds up to year.
  always_comb begin
    carryIn[IDX_SEC]  = strb.advance;
    carryIn[IDX_MIN]  = carryIn[IDX_SEC]  && atLimit[IDX_SEC];
    carryIn[IDX_HOUR] = carryIn[IDX_MIN]  && atLimit[IDX_MIN];
    carryIn[IDX_DAY]  = carryIn[IDX_HOUR] && atLimit[IDX_HOUR];
    carryIn[IDX_MON]  = carryIn[IDX_DAY]  && atLimit[IDX_DAY];
    carryIn[IDX_YEAR] = carryIn[IDX_MON]  && atLimit[IDX_MON];
    carryIn[IDX_WDAY] = carryIn[IDX_DAY];
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    logic [7:0] stepVal;

    assign atLimit[i] = timeQ[i] >= limitVal[i];

    if (i == IDX_WDAY) begin : g_bin
      assign stepVal = timeQ[i] + 8'd1;
    end else begin : g_bcd
      assign stepVal = bcdInc(timeQ[i]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               timeQ[i] <= fieldStart(i);
      else if (strb.wrTime[i]) timeQ[i] <= strb.wrByte & fieldMask(i);
      else if (carryIn[i])     timeQ[i] <= atLimit[i] ? fieldStart(i) : stepVal;
    end
  end

  assign timeBytes = timeQ;

  // R3: with neither an advance nor a write, the time holds
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && (strb.wrTime == '0)) |=> $stable(timeQ));

  // R5: seconds at 59 return to 00 on the next advance
  a_r5_sec_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && timeQ[IDX_SEC] == 8'h59) |=> (timeQ[IDX_SEC] == 8'h00));

  // R6: 30 November at 23:59:59 is followed by 31 November
  a_r6_nov_31: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && timeQ[IDX_MON] == 8'h11 && timeQ[IDX_DAY] == 8'h30 &&
     timeQ[IDX_HOUR] == 8'h23 && timeQ[IDX_MIN] == 8'h59 && timeQ[IDX_SEC] == 8'h59)
    |=> (timeQ[IDX_DAY] == 8'h31 && timeQ[IDX_MON] == 8'h11));

  // R9: an in-range weekday stays in range unless the host loads it
  a_r9_wday_range: assert property (@(posedge clk) disable iff (!rstN)
    (timeQ[IDX_WDAY] <= 8'h06 && !strb.wrTime[IDX_WDAY]) |=> (timeQ[IDX_WDAY] <= 8'h06));

endmodule

// File: rtl/bcd_rtc_regfile.sv
module bcd_rtc_regfile
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);

  rtcStrobe_t                 strb;
  logic                       stopBit;
  logic                       powerFlag;
  logic [NUM_FIELDS-1:0][7:0] timeBytes;

  rtc_ctrl #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickIn   (tickIn),
    .wrEn     (wrEn),
    .regAddr  (regAddr),
    .wrData   (wrData),
    .strb     (strb),
    .stopBit  (stopBit),
    .powerFlag(powerFlag)
  );

  rtc_time_path path_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .timeBytes(timeBytes)
  );

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (regAddr == ADDR_W'(i)) rdData = timeBytes[i];
    end
    if (regAddr == CTRL_ADDR) rdData = {7'd0, stopBit};
    if (regAddr == STAT_ADDR) rdData = {powerFlag, 7'd0};
  end

  // R4: a time write while running, with no tick, leaves the time untouched
  a_r4_running_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!stopBit && wrEn && regAddr < ADDR_W'(NUM_FIELDS) && !tickIn) |=> $stable(timeBytes));

endmodule

// File: tb/bcd_rtc_regfile_tb_top.sv
`timescale 1ns/100ps
module bcd_rtc_regfile_tb_top;

  localparam int ADDR_W = 4;
  localparam logic [3:0] A_SEC = 4'h0, A_MIN = 4'h1, A_HOUR = 4'h2, A_DAY = 4'h3,
                         A_MON = 4'h4, A_YEAR = 4'h5, A_WDAY = 4'h6,
                         A_CTRL = 4'h8, A_STAT = 4'h9;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] regAddr = 4'h0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  bcd_rtc_regfile #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [7:0] toBcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int lastDay(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, got, exp);
    end
  endtask

  task automatic readReg(input logic [3:0] a, output logic [7:0] v);
    regAddr = a;
    #0.1;
    v = rdData;
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tickIn = 1'b1;
    @(negedge clk);
    tickIn = 1'b0;
  endtask

  task automatic loadTime(input int y, input int mo, input int d, input int h,
                          input int mi, input int s, input int wd);
    writeReg(A_CTRL, 8'h01);
    writeReg(A_SEC, toBcd(s));
    writeReg(A_MIN, toBcd(mi));
    writeReg(A_HOUR, toBcd(h));
    writeReg(A_DAY, toBcd(d));
    writeReg(A_MON, toBcd(mo));
    writeReg(A_YEAR, toBcd(y));
    writeReg(A_WDAY, toBcd(wd));
    writeReg(A_CTRL, 8'h00);
  endtask

  task automatic checkTime(input string req, input int y, input int mo, input int d,
                           input int h, input int mi, input int s, input int wd);
    logic [7:0] v;
    readReg(A_SEC, v);  chk(req, "sec", v, toBcd(s));
    readReg(A_MIN, v);  chk(req, "min", v, toBcd(mi));
    readReg(A_HOUR, v); chk(req, "hour", v, toBcd(h));
    readReg(A_DAY, v);  chk(req, "day", v, toBcd(d));
    readReg(A_MON, v);  chk(req, "month", v, toBcd(mo));
    readReg(A_YEAR, v); chk(req, "year", v, toBcd(y));
    readReg(A_WDAY, v); chk(req, "wday", v, toBcd(wd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int s, mi, h;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkTime("R1", 0, 1, 1, 0, 0, 0, 0);
    readReg(A_CTRL, v); chk("R1", "ctrl", v, 8'h00);
    readReg(A_STAT, v); chk("R1", "status", v, 8'h80);

    // R2 unmapped offsets and unimplemented bits
    readReg(4'h7, v); chk("R2", "addr7", v, 8'h00);
    readReg(4'hF, v); chk("R2", "addrF", v, 8'h00);
    writeReg(A_CTRL, 8'hFF);
    readReg(A_CTRL, v); chk("R2", "ctrl bits", v, 8'h01);
    writeReg(A_SEC, 8'hFF);  readReg(A_SEC, v);  chk("R2", "sec mask", v, 8'h7F);
    writeReg(A_HOUR, 8'hFF); readReg(A_HOUR, v); chk("R2", "hour mask", v, 8'h3F);
    writeReg(A_MON, 8'hFF);  readReg(A_MON, v);  chk("R2", "month mask", v, 8'h1F);
    writeReg(A_WDAY, 8'hFF); readReg(A_WDAY, v); chk("R2", "wday mask", v, 8'h07);

    // R3 stopped: writes land, ticks ignored
    writeReg(A_SEC, 8'h42);
    readReg(A_SEC, v); chk("R3", "write while stopped", v, 8'h42);
    tick(); tick();
    readReg(A_SEC, v); chk("R3", "tick while stopped", v, 8'h42);

    // R4 running: time writes ignored
    loadTime(24, 3, 5, 22, 0, 0, 2);
    writeReg(A_SEC, 8'h33);
    writeReg(A_DAY, 8'h17);
    checkTime("R4", 24, 3, 5, 22, 0, 0, 2);

    // R5 digit carries across 3700 ticks
    s = 0; mi = 0; h = 22;
    for (int t = 0; t < 3700; t++) begin
      tick();
      s++;
      if (s == 60) begin s = 0; mi++; end
      if (mi == 60) begin mi = 0; h++; end
      readReg(A_SEC, v);  chk("R5", "sweep sec", v, toBcd(s));
      readReg(A_MIN, v);  chk("R5", "sweep min", v, toBcd(mi));
      readReg(A_HOUR, v); chk("R5", "sweep hour", v, toBcd(h));
    end

    // R6 R8 R9 month ends for a common and a leap year
    for (int yi = 0; yi < 2; yi++) begin
      for (int m = 1; m <= 12; m++) begin
        int y, ld;
        y = (yi == 0) ? 23 : 24;
        ld = lastDay(m, y);
        loadTime(y, m, ld - 1, 23, 59, 59, 3);
        tick();
        checkTime("R6", y, m, ld, 0, 0, 0, 4);
        loadTime(y, m, ld, 23, 59, 59, 6);
        tick();
        checkTime("R8", (m == 12) ? y + 1 : y, (m == 12) ? 1 : m + 1, 1, 0, 0, 0, 0);
      end
    end

    // R7 February end for every year value
    for (int y = 0; y < 100; y++) begin
      loadTime(y, 2, 28, 23, 59, 59, 1);
      tick();
      if (y % 4 == 0) checkTime("R7", y, 2, 29, 0, 0, 0, 2);
      else            checkTime("R7", y, 3, 1, 0, 0, 0, 2);
    end

    // R8 century wrap
    loadTime(99, 12, 31, 23, 59, 59, 5);
    tick();
    checkTime("R8", 0, 1, 1, 0, 0, 0, 6);

    // R11 out-of-range seconds
    writeReg(A_CTRL, 8'h01);
    writeReg(A_MIN, 8'h10);
    writeReg(A_SEC, 8'h75);
    writeReg(A_CTRL, 8'h00);
    tick();
    readReg(A_SEC, v); chk("R11", "sec from 75", v, 8'h00);
    readReg(A_MIN, v); chk("R11", "min carry", v, 8'h11);

    // R10 power-up flag
    writeReg(A_STAT, 8'h7F);
    readReg(A_STAT, v); chk("R10", "bit7 clear keeps flag", v, 8'h80);
    writeReg(A_STAT, 8'h80);
    readReg(A_STAT, v); chk("R10", "write one clears", v, 8'h00);
    writeReg(A_STAT, 8'h00);
    tick();
    readReg(A_STAT, v); chk("R10", "stays clear", v, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule